// File: doc/BRIEF.md
# Compare-Flag 8-bit ALU

This block is the arithmetic and logic stage of a small 8-bit core. Each cycle the core hands it two register operands, a 3-bit operation select and an enable. One clock edge later the block presents an 8-bit result with a write strobe for the destination register, which is always the first operand's register. Two further outputs are a 3-bit condition code and a one-cycle error pulse.

There are five data operations: add, multiply, AND, OR and XOR. A compare operation writes no register. It loads a one-hot less/greater/equal code that later conditional branches in the core test by exact match. The block does not produce carry, overflow or zero flags. The core reads the register file and decodes instructions. This block only computes, encodes the compare outcome and generates the write strobe.

Top module: `cflag_alu`

## Requirements
- R1: With enable high and select 3'd0 (add), the cycle after the edge shows write strobe 1 and result equal to (A + B) mod 256, unsigned.
- R2: With enable high and select 3'd1 (multiply), the cycle after the edge shows write strobe 1 and the low 8 bits of the unsigned product A * B.
- R3: With enable high, select 3'd2 gives A AND B, 3'd3 gives A OR B and 3'd4 gives A XOR B, each with write strobe 1 on the next cycle.
- R4: With enable high and select 3'd5 (compare), the condition code becomes 3'b100 when A < B, 3'b010 when A > B and 3'b001 when A = B. Bit 2 is less, bit 1 is greater and bit 0 is equal. At most one bit is ever set.
- R5: A compare gives write strobe 0 and result 0 on the next cycle.
- R6: Every operation other than compare leaves the condition code unchanged.
- R7: While reset (active-low, synchronous) is applied, the condition code, result, write strobe and error output are all 0. A branch on "equal" is therefore not taken before the first compare.
- R8: With enable high and select 3'd6 or 3'd7, the error output is 1 for exactly the next cycle. Write strobe and result are 0 in that cycle, and the condition code is unchanged.
- R9: With enable low, the next cycle shows write strobe 0, result 0 and error 0, and the condition code is unchanged.
- R10: The result output is 0 in every cycle in which the write strobe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Operation request for this cycle |
| op_sel | input | 3 | Operation select (0 add, 1 mul, 2 and, 3 or, 4 xor, 5 cmp) |
| opnd_a | input | 8 | First operand; its register is the destination |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Registered result |
| wr_en | output | 1 | Registered write strobe for the first operand's register |
| flags | output | 3 | Condition code: less, greater, equal |
| op_err | output | 1 | One-cycle pulse for an unsupported select |

## Verification
The assertions assume that op_sel and the operands are settled and known at each rising edge whenever enable is high. They also assume that reset is held for at least one edge before the first request. The bench changes every input only on the falling edge and keeps reset low for several cycles at start-up. A directed sequence covers wrap-around on add and multiply, all three compare outcomes and both invalid selects. Free-running stimulus then mixes invalid selects and idle cycles among valid operations.

// File: rtl/alu8_pkg.sv
// Package: shared widths, operation codes and decoded-operation type for the
// compare-flag ALU. Assumes a 3-bit select space with codes 6 and 7 unused.
package alu8_pkg;

    localparam int SEL_W  = 3;
    localparam int CODE_W = 3;

    typedef enum logic [SEL_W-1:0] {
        OPC_ADD = 3'd0,
        OPC_MUL = 3'd1,
        OPC_AND = 3'd2,
        OPC_OR  = 3'd3,
        OPC_XOR = 3'd4,
        OPC_CMP = 3'd5
    } alu_opc_e;

    // Condition-code bit positions (branches match the whole code exactly)
    localparam int CC_LT = 2;
    localparam int CC_GT = 1;
    localparam int CC_EQ = 0;

    typedef struct packed {
        logic is_add;
        logic is_mul;
        logic is_and;
        logic is_or;
        logic is_xor;
        logic is_cmp;
        logic is_bad;
    } op_dec_t;

endpackage

// File: rtl/alu8_decode.sv
// Module: turns the raw operation select into one-hot operation flags.
// Assumes select is stable when sampled; unknown codes raise is_bad.
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [SEL_W-1:0] op_sel,
    output op_dec_t          dec,
    output logic             writes
);

    // Decode select into exactly one operation flag
    always_comb begin
        dec = '0;
        case (op_sel)
            OPC_ADD: dec.is_add = 1'b1;
            OPC_MUL: dec.is_mul = 1'b1;
            OPC_AND: dec.is_and = 1'b1;
            OPC_OR:  dec.is_or  = 1'b1;
            OPC_XOR: dec.is_xor = 1'b1;
            OPC_CMP: dec.is_cmp = 1'b1;
            default: dec.is_bad = 1'b1;
        endcase
    end

    // Register write happens for the data operations only
    always_comb begin
        writes = dec.is_add | dec.is_mul | dec.is_and | dec.is_or | dec.is_xor;
    end

endmodule

// File: rtl/alu8_mul.sv
// Module: unsigned multiplier keeping only the low DATA_W bits, built as a
// shift-and-add chain. Assumes truncation is the desired wrap behaviour.
module alu8_mul #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] mul_a,
    input  logic [DATA_W-1:0] mul_b,
    output logic [DATA_W-1:0] mul_lo
);

    logic [DATA_W-1:0] acc [DATA_W+1];

    assign acc[0] = '0;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_pp
            logic [DATA_W-1:0] pp;
            // Partial product for bit gi of the second operand, shifted and truncated
            always_comb begin
                pp = mul_b[gi] ? (mul_a << gi) : '0;
            end
            assign acc[gi+1] = acc[gi] + pp;
        end
    endgenerate

    assign mul_lo = acc[DATA_W];

endmodule

// File: rtl/alu8_compare.sv
// Module: unsigned magnitude compare producing a one-hot less/greater/equal
// code. Assumes both operands are the same width.
module alu8_compare
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    output logic [CODE_W-1:0] cmp_code
);

    // Build the one-hot outcome code
    always_comb begin
        cmp_code        = '0;
        cmp_code[CC_LT] = (cmp_a <  cmp_b);
        cmp_code[CC_GT] = (cmp_a >  cmp_b);
        cmp_code[CC_EQ] = (cmp_a == cmp_b);
    end

endmodule

// File: rtl/cflag_alu.sv
// Module: top of the compare-flag ALU. Selects the data result, registers the
// write strobe, result and error pulse, and holds the condition code that
// only a compare may change. Assumes inputs are valid at each rising edge.
module cflag_alu
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [2:0]        flags,
    output logic              op_err
);

    op_dec_t             dec;
    logic                writes;
    logic [DATA_W-1:0]   mul_lo;
    logic [CODE_W-1:0]   cmp_code;
    logic [DATA_W-1:0]   nxt_res;

    logic [DATA_W-1:0]   res_q;
    logic                wr_q;
    logic                err_q;
    logic [CODE_W-1:0]   cc_q;

    alu8_decode u_dec (
        .op_sel (op_sel),
        .dec    (dec),
        .writes (writes)
    );

    alu8_mul #(.DATA_W(DATA_W)) u_mul (
        .mul_a  (opnd_a),
        .mul_b  (opnd_b),
        .mul_lo (mul_lo)
    );

    alu8_compare #(.DATA_W(DATA_W)) u_cmp (
        .cmp_a    (opnd_a),
        .cmp_b    (opnd_b),
        .cmp_code (cmp_code)
    );

    // Select the data result for the decoded operation (sum wraps)
    always_comb begin
        nxt_res = '0;
        unique case (1'b1)
            dec.is_add: nxt_res = opnd_a + opnd_b;
            dec.is_mul: nxt_res = mul_lo;
            dec.is_and: nxt_res = opnd_a & opnd_b;
            dec.is_or:  nxt_res = opnd_a | opnd_b;
            dec.is_xor: nxt_res = opnd_a ^ opnd_b;
            default:    nxt_res = '0;
        endcase
    end

    // Register write strobe, result and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            wr_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            wr_q  <= en & writes;
            res_q <= (en & writes) ? nxt_res : '0;
            err_q <= en & dec.is_bad;
        end
    end

    // Condition code: loaded only by an enabled compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= '0;
        end else if (en && dec.is_cmp) begin
            cc_q <= cmp_code;
        end
    end

    assign result = res_q;
    assign wr_en  = wr_q;
    assign flags  = cc_q;
    assign op_err = err_q;

    AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags)); // R4

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_sel == 3'd5) |=> (!wr_en && result == '0)); // R5

    AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_sel != 3'd5) |=> $stable(flags)); // R6

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_sel > 3'd5) |=> (op_err && !wr_en)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!wr_en && !op_err && $stable(flags))); // R9

    AST_RES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (result == '0)); // R10

endmodule

// File: tb/tb_cflag_alu.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with the outputs on every falling edge.
module tb_cflag_alu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic [7:0] result;
    logic       wr_en;
    logic [2:0] flags;
    logic       op_err;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    int    m_res = 0, m_wr = 0, m_err = 0, m_flg = 0;
    string t_res = "R7", t_flg = "R7";

    always #4 clk = ~clk;

    cflag_alu dut (
        .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .wr_en(wr_en), .flags(flags), .op_err(op_err)
    );

    // Reference model: one update per rising edge
    always @(posedge clk) begin
        int ia, ib;
        ia = opnd_a;
        ib = opnd_b;
        cyc = cyc + 1;
        if (!rst_n) begin
            m_res = 0; m_wr = 0; m_err = 0; m_flg = 0;
            t_res = "R7"; t_flg = "R7";
        end else if (!en) begin
            m_res = 0; m_wr = 0; m_err = 0;
            t_res = "R9"; t_flg = "R9";
        end else begin
            m_err = 0; m_wr = 1; t_flg = "R6";
            case (op_sel)
                3'd0: begin m_res = (ia + ib) % 256; t_res = "R1"; end
                3'd1: begin m_res = (ia * ib) % 256; t_res = "R2"; end
                3'd2: begin m_res = ia & ib; t_res = "R3"; end
                3'd3: begin m_res = ia | ib; t_res = "R3"; end
                3'd4: begin m_res = ia ^ ib; t_res = "R3"; end
                3'd5: begin
                    m_res = 0; m_wr = 0; t_res = "R5"; t_flg = "R4";
                    m_flg = (ia < ib) ? 4 : ((ia > ib) ? 2 : 1);
                end
                default: begin
                    m_res = 0; m_wr = 0; m_err = 1; t_res = "R8"; t_flg = "R8";
                end
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Compare every output on the falling edge
    always @(negedge clk) begin
        if (cyc > 0) begin
            chk(t_res, (^result === 1'bx) ? -1 : int'(result), m_res, "result");
            chk(t_res, (wr_en === 1'bx) ? -1 : int'(wr_en), m_wr, "wr_en");
            chk(t_flg, (^flags === 1'bx) ? -1 : int'(flags), m_flg, "flags");
            chk((m_err != 0) ? "R8" : t_res, (op_err === 1'bx) ? -1 : int'(op_err), m_err, "op_err");
            if (wr_en === 1'b0) chk("R10", int'(result), 0, "result while idle");
        end
    end

    task automatic op(input int s, input int a, input int b);
        @(negedge clk);
        en = 1'b1; op_sel = 3'(s); opnd_a = 8'(a); opnd_b = 8'(b);
    endtask

    task automatic idle();
        @(negedge clk);
        en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        op(0, 200, 100);   // R1 wrap to 44
        op(0, 5, 6);
        op(1, 20, 13);     // R2 260 -> 4
        op(1, 255, 255);
        op(2, 8'hF0, 8'h3C); // R3
        op(3, 8'hF0, 8'h3C);
        op(4, 8'hF0, 8'h3C);
        op(5, 3, 9);       // R4 less
        op(0, 1, 1);       // R6 hold
        op(5, 9, 3);       // R4 greater
        op(6, 1, 2);       // R8
        op(7, 1, 2);
        op(5, 7, 7);       // R4 equal
        idle();            // R9
        idle();
        op(5, 0, 255);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            en     = ($urandom % 5) != 0;
            op_sel = 3'($urandom % 8);
            opnd_a = 8'($urandom);
            opnd_b = ($urandom % 4 == 0) ? opnd_a : 8'($urandom);
        end
        idle();
        @(negedge clk);
        rst_n = 1'b0;      // R7 re-applied
        @(negedge clk);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule